// File: doc/BRIEF.md
# Serial Port to I2S Bridge

This block sits between a frame-pulse style synchronous serial engine and the audio pads of the chip. It presents the engine's transfers on the pads as I2S. When it is enabled, its single-cycle frame pulse becomes a word-select level that alternates between left and right channel words. The incoming word-select level changes go back to the engine as one-bit frame pulses. Data and framing are moved from the engine's edge convention to the I2S one. The engine launches on the rising bit-clock edge and captures on the falling edge. I2S captures everything on the rising edge.

A source select chooses where the bit clock comes from. In master mode the bit clock and the word select that drive the pads come from the engine. In slave mode an external codec drives both through the pads, and the engine receives that clock. While the block is enabled, the transmit pad is always driven. While it is disabled, the block is a transparent wire in both directions.

The block runs on a fast system clock and oversamples the selected bit clock through a synchronizer of `SYNC_STAGES` flops. Bit-clock edges are detected on that sampled copy. Each bit-clock half period must last at least `SYNC_STAGES + 2` system clocks. Correct channel alignment assumes the engine runs continuously and in full duplex. Receive-only operation is not supported.

Top module: `i2s_bridge`

## Requirements
- R1: While reset is high with the block enabled: `pad_ws_out` is 1, and `pad_tx_bit`, `to_eng_frame` and `to_eng_rx_bit` are 0.
- R2: With `src_ssp`=1 (master), three things hold. `pad_bclk_out` follows `eng_bclk`. `pad_ctl_oe` is 1. While enabled, `to_eng_bclk` follows `eng_bclk`, and the receive channel tracker uses the block's own word select, ignoring `pad_ws_in`.
- R3: With `src_ssp`=0 (slave), three things hold. `pad_ctl_oe` is 0. `to_eng_bclk` follows `pad_bclk_in`. The receive channel tracker follows `pad_ws_in`, and `pad_bclk_in` is the bit clock that times both paths.
- R4: While `en`=1, `pad_tx_oe_n` is 0 (pad driven) whatever `eng_tx_oe_n` is.
- R5: While `en`=0, the following pass straight through: `pad_tx_bit`=`eng_tx_bit`, `pad_ws_out`=`eng_frame`, `pad_tx_oe_n`=`eng_tx_oe_n`, `to_eng_frame`=`pad_ws_in`, `to_eng_rx_bit`=`pad_rx_bit` and `to_eng_bclk`=`pad_bclk_in`.
- R6: While enabled, `eng_tx_bit` is captured at each falling bit-clock edge. It appears on `pad_tx_bit` at the next rising edge and is held until the rising edge after that.
- R7: While enabled, a 1 on `eng_frame` captured at a falling edge inverts `pad_ws_out` at the next rising edge. `pad_ws_out` changes at no other time.
- R8: While enabled, `pad_rx_bit` is sampled at each rising bit-clock edge and held on `to_eng_rx_bit` until the next rising edge.
- R9: While enabled, `to_eng_frame` is 1 for exactly the bit period that starts at a rising edge where the sampled word select differs from the value sampled at the previous rising edge.
- R10: While `en`=0, both channel trackers return to the right channel (word select 1). After enable, `pad_ws_out` is 1, and the first captured frame pulse moves it to 0 (left).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | 1 = bridge active, 0 = transparent bypass |
| src_ssp | input | 1 | 1 = master (clocks from engine), 0 = slave (clocks from pads) |
| eng_bclk | input | 1 | Bit clock generated by the serial engine |
| eng_frame | input | 1 | Single-cycle frame pulse from the engine |
| eng_tx_bit | input | 1 | Transmit data from the engine |
| eng_tx_oe_n | input | 1 | Engine's active-low transmit pad enable |
| to_eng_bclk | output | 1 | Bit clock delivered to the engine |
| to_eng_frame | output | 1 | Frame pulse delivered to the engine |
| to_eng_rx_bit | output | 1 | Receive data delivered to the engine |
| pad_bclk_in | input | 1 | Bit clock from the bit-clock pad (slave mode) |
| pad_ws_in | input | 1 | Word select from the word-select pad (slave mode) |
| pad_rx_bit | input | 1 | Receive data pad |
| pad_bclk_out | output | 1 | Bit clock driven toward the bit-clock pad |
| pad_ws_out | output | 1 | Word select driven toward the word-select pad |
| pad_ctl_oe | output | 1 | Output enable for the bit-clock and word-select pads |
| pad_tx_bit | output | 1 | Transmit data pad |
| pad_tx_oe_n | output | 1 | Active-low output enable of the transmit data pad |

## Verification
The bench toggles the bit clock itself and, at each edge, updates a behavioural model of both paths. Four-bit channel words carry uneven data so that a bit launched one edge early or late shows up as a mismatch. In master mode, pulses on the pad word-select input are injected that must be ignored. This separates the internal word-select source from the pad source. In slave mode a codec-style word select alternates, testing pulse regeneration at each change. Random stimulus in bypass, plus a disable/re-enable in mid-word, separate transparent pass-through and the tracker restart from any state left behind.

// File: rtl/i2sb_pkg.sv
package i2sb_pkg;

    // Word-select level that means "right channel"; trackers idle here so
    // the first frame pulse after enable opens a left word.
    localparam logic WS_RIGHT = 1'b1;

    // Inputs sampled together through the synchronizer.
    typedef struct packed {
        logic bclk;
        logic frame;
        logic tx_bit;
        logic ws;
        logic rx_bit;
    } smp_t;

    localparam int SMP_W = $bits(smp_t);

    typedef struct packed {
        logic cap_bit;
        logic cap_frame;
        logic launch_bit;
        logic ws;
    } tx_state_t;

    typedef struct packed {
        logic rx_bit;
        logic frame;
        logic ws_prev;
    } rx_state_t;

    localparam tx_state_t TX_IDLE = '{cap_bit: 1'b0, cap_frame: 1'b0,
                                      launch_bit: 1'b0, ws: WS_RIGHT};
    localparam rx_state_t RX_IDLE = '{rx_bit: 1'b0, frame: 1'b0,
                                      ws_prev: WS_RIGHT};

    function automatic logic ws_after_pulse(input logic ws, input logic pulse);
        return pulse ? ~ws : ws;
    endfunction

endpackage

// File: rtl/i2sb_sync.sv
module i2sb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/i2sb_edge.sv
module i2sb_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/i2sb_tx.sv
module i2sb_tx
    import i2sb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic rise,
    input  logic fall,
    input  logic tx_bit_in,
    input  logic frame_in,
    output logic tx_bit_out,
    output logic ws_out
);
    tx_state_t st, st_nx;

    always_comb begin
        st_nx = st;
        if (fall) begin
            st_nx.cap_bit   = tx_bit_in;
            st_nx.cap_frame = frame_in;
        end
        if (rise) begin
            st_nx.launch_bit = st.cap_bit;
            st_nx.ws         = ws_after_pulse(st.ws, st.cap_frame);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) st <= TX_IDLE;
        else            st <= st_nx;
    end

    assign tx_bit_out = st.launch_bit;
    assign ws_out     = st.ws;
endmodule

// File: rtl/i2sb_rx.sv
module i2sb_rx
    import i2sb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic rise,
    input  logic rx_bit_in,
    input  logic ws_in,
    output logic rx_bit_out,
    output logic frame_out
);
    rx_state_t st, st_nx;

    always_comb begin
        st_nx = st;
        if (rise) begin
            st_nx.rx_bit  = rx_bit_in;
            st_nx.frame   = ws_in ^ st.ws_prev;
            st_nx.ws_prev = ws_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) st <= RX_IDLE;
        else            st <= st_nx;
    end

    assign rx_bit_out = st.rx_bit;
    assign frame_out  = st.frame;
endmodule

// File: rtl/i2s_bridge.sv
module i2s_bridge
    import i2sb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic src_ssp,
    input  logic eng_bclk,
    input  logic eng_frame,
    input  logic eng_tx_bit,
    input  logic eng_tx_oe_n,
    output logic to_eng_bclk,
    output logic to_eng_frame,
    output logic to_eng_rx_bit,
    input  logic pad_bclk_in,
    input  logic pad_ws_in,
    input  logic pad_rx_bit,
    output logic pad_bclk_out,
    output logic pad_ws_out,
    output logic pad_ctl_oe,
    output logic pad_tx_bit,
    output logic pad_tx_oe_n
);
    smp_t             smp_raw, smp_q;
    logic [SMP_W-1:0] smp_vec;
    logic             bclk_rise, bclk_fall;
    logic             tx_bit_r, tx_ws_r, rx_bit_r, rx_frame_r, rx_ws_src;

    always_comb begin
        smp_raw.bclk   = src_ssp ? eng_bclk : pad_bclk_in;
        smp_raw.frame  = eng_frame;
        smp_raw.tx_bit = eng_tx_bit;
        smp_raw.ws     = pad_ws_in;
        smp_raw.rx_bit = pad_rx_bit;
    end

    i2sb_sync #(.W(SMP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .d (smp_raw), .q (smp_vec)
    );

    assign smp_q = smp_vec;

    i2sb_edge u_edge (
        .clk (clk), .rst (rst), .lvl (smp_q.bclk),
        .rise (bclk_rise), .fall (bclk_fall)
    );

    i2sb_tx u_tx (
        .clk (clk), .rst (rst), .en (en),
        .rise (bclk_rise), .fall (bclk_fall),
        .tx_bit_in (smp_q.tx_bit), .frame_in (smp_q.frame),
        .tx_bit_out (tx_bit_r), .ws_out (tx_ws_r)
    );

    // Master: receive side follows the word select this block drives.
    assign rx_ws_src = src_ssp ? tx_ws_r : smp_q.ws;

    i2sb_rx u_rx (
        .clk (clk), .rst (rst), .en (en), .rise (bclk_rise),
        .rx_bit_in (smp_q.rx_bit), .ws_in (rx_ws_src),
        .rx_bit_out (rx_bit_r), .frame_out (rx_frame_r)
    );

    assign pad_bclk_out  = eng_bclk;
    assign pad_ctl_oe    = src_ssp;
    assign to_eng_bclk   = (en && src_ssp) ? eng_bclk : pad_bclk_in;
    assign pad_tx_bit    = en ? tx_bit_r   : eng_tx_bit;
    assign pad_ws_out    = en ? tx_ws_r    : eng_frame;
    assign pad_tx_oe_n   = en ? 1'b0       : eng_tx_oe_n;
    assign to_eng_rx_bit = en ? rx_bit_r   : pad_rx_bit;
    assign to_eng_frame  = en ? rx_frame_r : pad_ws_in;
endmodule

// File: rtl/i2s_bridge_chk.sv
module i2s_bridge_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic bclk_rise,
    input logic pad_tx_bit,
    input logic pad_ws_out,
    input logic to_eng_rx_bit,
    input logic to_eng_frame
);
    // R6: launched transmit bit moves only after a detected rising edge
    a_r6_tx_bit_holds: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(bclk_rise)) |-> $stable(pad_tx_bit));

    // R7: word select moves only after a detected rising edge
    a_r7_ws_holds: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(bclk_rise)) |-> $stable(pad_ws_out));

    // R8: received bit is held between rising edges
    a_r8_rx_bit_holds: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(bclk_rise)) |-> $stable(to_eng_rx_bit));

    // R9: regenerated frame pulse spans whole bit periods
    a_r9_frame_holds: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(bclk_rise)) |-> $stable(to_eng_frame));

    // R10: enabling starts from the right channel
    a_r10_restart_right: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> pad_ws_out);
endmodule

bind i2s_bridge i2s_bridge_chk u_chk (
    .clk (clk), .rst (rst), .en (en), .bclk_rise (bclk_rise),
    .pad_tx_bit (pad_tx_bit), .pad_ws_out (pad_ws_out),
    .to_eng_rx_bit (to_eng_rx_bit), .to_eng_frame (to_eng_frame)
);

// File: tb/i2s_bridge_tb_top.sv
`timescale 1ns/1ps
module i2s_bridge_tb_top;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst, en, src_ssp;
    logic eng_bclk, eng_frame, eng_tx_bit, eng_tx_oe_n;
    logic pad_bclk_in, pad_ws_in, pad_rx_bit;
    logic to_eng_bclk, to_eng_frame, to_eng_rx_bit;
    logic pad_bclk_out, pad_ws_out, pad_ctl_oe, pad_tx_bit, pad_tx_oe_n;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // behavioural reference state
    logic m_cap_bit, m_cap_frm, m_tx_bit, m_ws, m_rx_bit, m_rfrm, m_prev;

    always #4 clk = ~clk;

    i2s_bridge dut_i (
        .clk (clk), .rst (rst), .en (en), .src_ssp (src_ssp),
        .eng_bclk (eng_bclk), .eng_frame (eng_frame),
        .eng_tx_bit (eng_tx_bit), .eng_tx_oe_n (eng_tx_oe_n),
        .to_eng_bclk (to_eng_bclk), .to_eng_frame (to_eng_frame),
        .to_eng_rx_bit (to_eng_rx_bit),
        .pad_bclk_in (pad_bclk_in), .pad_ws_in (pad_ws_in),
        .pad_rx_bit (pad_rx_bit), .pad_bclk_out (pad_bclk_out),
        .pad_ws_out (pad_ws_out), .pad_ctl_oe (pad_ctl_oe),
        .pad_tx_bit (pad_tx_bit), .pad_tx_oe_n (pad_tx_oe_n)
    );

    task automatic chk(input string req, input string what,
                       input logic got, input logic exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic model_idle();
        m_cap_bit = 0; m_cap_frm = 0; m_tx_bit = 0; m_ws = 1;
        m_rx_bit = 0; m_rfrm = 0; m_prev = 1;
    endtask

    task automatic model_rise();
        logic wsrc;
        if (!en) return;
        wsrc     = src_ssp ? m_ws : pad_ws_in;
        m_rx_bit = pad_rx_bit;
        m_rfrm   = wsrc ^ m_prev;
        m_prev   = wsrc;
        m_tx_bit = m_cap_bit;
        if (m_cap_frm) m_ws = ~m_ws;
    endtask

    task automatic model_fall();
        if (!en) return;
        m_cap_bit = eng_tx_bit;
        m_cap_frm = eng_frame;
    endtask

    task automatic compare_all();
        chk("R2", "pad_bclk_out", pad_bclk_out, eng_bclk);
        chk(src_ssp ? "R2" : "R3", "pad_ctl_oe", pad_ctl_oe, src_ssp);
        chk(en ? (src_ssp ? "R2" : "R3") : "R5", "to_eng_bclk", to_eng_bclk,
            (en && src_ssp) ? eng_bclk : pad_bclk_in);
        chk(en ? "R4" : "R5", "pad_tx_oe_n", pad_tx_oe_n, en ? 1'b0 : eng_tx_oe_n);
        chk(en ? "R6" : "R5", "pad_tx_bit", pad_tx_bit, en ? m_tx_bit : eng_tx_bit);
        chk(en ? "R7" : "R5", "pad_ws_out", pad_ws_out, en ? m_ws : eng_frame);
        chk(en ? "R8" : "R5", "to_eng_rx_bit", to_eng_rx_bit, en ? m_rx_bit : pad_rx_bit);
        chk(en ? "R9" : "R5", "to_eng_frame", to_eng_frame, en ? m_rfrm : pad_ws_in);
    endtask

    task automatic set_bclk(input logic b);
        if (src_ssp) eng_bclk = b;
        else         pad_bclk_in = b;
    endtask

    task automatic bit_period(input logic txd, input logic frm,
                              input logic rxd, input logic ws);
        @(negedge clk);
        set_bclk(1'b1);
        eng_tx_bit = txd; eng_frame = frm;
        model_rise();
        repeat (HALF) @(negedge clk);
        compare_all();
        set_bclk(1'b0);
        pad_rx_bit = rxd; pad_ws_in = ws;
        model_fall();
        repeat (HALF) @(negedge clk);
        compare_all();
    endtask

    task automatic go_idle_switch(input logic master);
        @(negedge clk);
        en = 0; model_idle();
        eng_bclk = 0; pad_bclk_in = 0; eng_frame = 0;
        repeat (4) @(negedge clk);
        src_ssp = master;
        repeat (4) @(negedge clk);
        en = 1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] txp, rxp;
        txp = 16'hB4C9; rxp = 16'h5A3E;
        rst = 1; en = 1; src_ssp = 1;
        eng_bclk = 0; eng_frame = 0; eng_tx_bit = 0; eng_tx_oe_n = 1;
        pad_bclk_in = 0; pad_ws_in = 0; pad_rx_bit = 0;
        model_idle();
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", "pad_ws_out", pad_ws_out, 1'b1);
        chk("R1", "pad_tx_bit", pad_tx_bit, 1'b0);
        chk("R1", "to_eng_frame", to_eng_frame, 1'b0);
        chk("R1", "to_eng_rx_bit", to_eng_rx_bit, 1'b0);
        chk("R4", "pad_tx_oe_n", pad_tx_oe_n, 1'b0);
        rst = 0;
        repeat (4) @(negedge clk);

        // master mode: pad word select is noise and must be ignored (R2)
        for (int k = 0; k < 16; k++)
            bit_period(txp[k], (k % 4) == 3, rxp[k], (k % 3) == 0);

        // slave mode: codec-style word select alternates every 4 bits (R3)
        go_idle_switch(1'b0);
        for (int k = 0; k < 16; k++)
            bit_period(~txp[k], (k % 4) == 0, rxp[15-k], ((k >> 2) & 1) == 1);

        // R10: stop mid-word with left channel current, restart
        go_idle_switch(1'b1);
        for (int k = 0; k < 3; k++)
            bit_period(txp[k], k == 0, rxp[k], 1'b0);
        chk("R10", "pad_ws_out before restart", pad_ws_out, 1'b0);
        go_idle_switch(1'b1);
        chk("R10", "pad_ws_out after enable", pad_ws_out, 1'b1);
        bit_period(1'b1, 1'b1, 1'b0, 1'b0);
        bit_period(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10", "pad_ws_out first word left", pad_ws_out, 1'b0);

        // R5: transparent bypass under varied inputs
        @(negedge clk);
        en = 0; model_idle();
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            {eng_bclk, eng_frame, eng_tx_bit, eng_tx_oe_n} = 4'(i * 7 + 3);
            {pad_bclk_in, pad_ws_in, pad_rx_bit} = 3'(i * 5 + 1);
            src_ssp = i[3];
            #1;
            compare_all();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule